// File: doc/BRIEF.md
# Scan-Chain State Register with Access Sequencer

This block is a W-bit state register whose flip-flops can also be strung together as one serial shift path. Each bit has a two-way selector on its data input. In functional mode it takes the matching bit of the next-state bus from the surrounding combinational logic. In scan mode it takes the output of the bit below it in the path. Bit 0 is fed by the serial input and bit W-1 drives the serial output.

A small sequencer owns the scan-mode select and the serial input, and it gathers the serial output back into a parallel word. It accepts two commands over a valid/ready handshake.

- The load command places an arbitrary W-bit value into the register in W shift clocks, whatever the register held and whatever the next-state logic computes.
- The unload command first applies one functional clock, which captures the next-state bus. It then applies W-1 shift clocks and presents the captured value as a parallel word, together with a one-cycle done pulse.

Outside a command the register behaves as an ordinary state register.

Top module: `scan_state_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the register, `result` and `done` go to zero, `test_mode` goes low and `cmd_ready` goes high.
- R2: Whenever `test_mode` is low, each clock edge copies `nxt_state` into `cur_state`.
- R3: `cmd_op` = 0 selects the load command. After it is accepted, `test_mode` is high for exactly W consecutive cycles, and `scan_si` presents `cmd_data` most significant bit first, one bit per cycle. In the following cycle `done` is high, `test_mode` is low and `cur_state` equals `cmd_data`.
- R4: While `test_mode` is high, each clock edge moves `cur_state[i-1]` into `cur_state[i]` and `scan_si` into `cur_state[0]`. `scan_so` always equals `cur_state[W-1]`.
- R5: `cmd_op` = 1 selects the unload command. Call the cycle after acceptance the capture cycle. In that cycle `test_mode` is low. It is followed by exactly W-1 cycles with `test_mode` high and then one cycle with `test_mode` low, during which `scan_so` shows the captured bit 0. In the cycle after that, `done` is high and `result` equals the `nxt_state` value present in the capture cycle.
- R6: `cmd_ready` is high only when no command is in progress. `cmd_valid` while `cmd_ready` is low is ignored: the running command completes unchanged and no further command starts.
- R7: `done` is high for one cycle per command. `result` changes only when an unload completes and holds its value otherwise, including across load commands.
- R8: After a command completes, `test_mode` stays low and the register follows `nxt_state` on every clock again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Sequencer idle; a command is accepted when valid and ready are both high |
| cmd_op | input | 1 | 0 = load, 1 = capture and unload |
| cmd_data | input | W | Value to load |
| nxt_state | input | W | Next-state bus from the combinational logic |
| cur_state | output | W | Present-state bus |
| test_mode | output | 1 | Scan-mode select driven to every bit |
| scan_si | output | 1 | Serial value driven into bit 0 |
| scan_so | output | 1 | Serial output, the top bit of the register |
| done | output | 1 | One-cycle command completion pulse |
| result | output | W | Last unloaded word |

## Verification
The bench builds the block with W = 3 and closes the loop through a small 3-bit next-state function that it computes itself. At this width every one of the eight states can be loaded and every captured value can be unloaded. The bench therefore checks the whole value space of both directions, as well as the serial bit order on the input and output pins. The short chain also makes the one-shift-fewer unload and the tail cycle easy to count against the W-cycle load window.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_LOAD    = 3'd1,
    SQ_CAPTURE = 3'd2,
    SQ_UNLOAD  = 3'd3,
    SQ_TAIL    = 3'd4
  } seq_state_t;

  localparam logic OP_LOAD   = 1'b0;
  localparam logic OP_UNLOAD = 1'b1;
endpackage

// File: rtl/scan_cell.sv
module scan_cell (
  input  logic clk,
  input  logic rst,
  input  logic sel_scan,
  input  logic d_func,
  input  logic d_scan,
  output logic q
);
  logic d_mux;

  always_comb d_mux = sel_scan ? d_scan : d_func;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d_mux;
  end
endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         test_mode,
  input  logic         scan_si,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] q,
  output logic         scan_so
);
  logic [W:0] link;

  assign link[0] = scan_si;

  for (genvar i = 0; i < W; i++) begin : g_cell
    scan_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .sel_scan (test_mode),
      .d_func   (nxt[i]),
      .d_scan   (link[i]),
      .q        (q[i])
    );
    assign link[i+1] = q[i];
  end

  assign scan_so = link[W];
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_pkg::*;
#(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic         cmd_op,
  input  logic [W-1:0] cmd_data,
  input  logic         scan_so,
  output logic         test_mode,
  output logic         scan_si,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_LOAD   = CW'(W - 1);
  localparam logic [CW-1:0] LAST_UNLOAD = CW'(W - 2);

  seq_state_t   st_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  src_q;
  logic [W-1:0]  col_q;
  logic [W-1:0]  res_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      src_q  <= '0;
      col_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        SQ_IDLE: begin
          cnt_q <= '0;
          if (cmd_valid) begin
            if (cmd_op == OP_LOAD) begin
              src_q <= cmd_data;
              st_q  <= SQ_LOAD;
            end else begin
              st_q  <= SQ_CAPTURE;
            end
          end
        end
        SQ_LOAD: begin
          src_q <= {src_q[W-2:0], 1'b0};
          if (cnt_q == LAST_LOAD) begin
            st_q   <= SQ_IDLE;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SQ_CAPTURE: begin
          cnt_q <= '0;
          st_q  <= SQ_UNLOAD;
        end
        SQ_UNLOAD: begin
          col_q <= {col_q[W-2:0], scan_so};
          if (cnt_q == LAST_UNLOAD) st_q <= SQ_TAIL;
          else                      cnt_q <= cnt_q + 1'b1;
        end
        SQ_TAIL: begin
          res_q  <= {col_q[W-2:0], scan_so};
          done_q <= 1'b1;
          st_q   <= SQ_IDLE;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st_q == SQ_IDLE);
  assign test_mode = (st_q == SQ_LOAD) || (st_q == SQ_UNLOAD);
  assign scan_si   = src_q[W-1];
  assign done      = done_q;
  assign result    = res_q;
endmodule

// File: rtl/scan_state_ctrl.sv
module scan_state_ctrl #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic         cmd_op,
  input  logic [W-1:0] cmd_data,
  input  logic [W-1:0] nxt_state,
  output logic [W-1:0] cur_state,
  output logic         test_mode,
  output logic         scan_si,
  output logic         scan_so,
  output logic         done,
  output logic [W-1:0] result
);
  scan_chain #(.W(W)) u_chain (
    .clk       (clk),
    .rst       (rst),
    .test_mode (test_mode),
    .scan_si   (scan_si),
    .nxt       (nxt_state),
    .q         (cur_state),
    .scan_so   (scan_so)
  );

  scan_sequencer #(.W(W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data),
    .scan_so   (scan_so),
    .test_mode (test_mode),
    .scan_si   (scan_si),
    .done      (done),
    .result    (result)
  );
endmodule

// File: rtl/scan_state_chk.sv
module scan_state_chk #(
  parameter int W = 3
) (
  input logic         clk,
  input logic         rst,
  input logic         cmd_ready,
  input logic         test_mode,
  input logic         scan_si,
  input logic [W-1:0] nxt_state,
  input logic [W-1:0] cur_state,
  input logic         done,
  input logic [W-1:0] result
);
  localparam int RW = $clog2(W + 1) + 1;
  logic [RW-1:0] tm_run;

  always_ff @(posedge clk) begin
    if (rst)            tm_run <= '0;
    else if (test_mode) tm_run <= tm_run + 1'b1;
    else                tm_run <= '0;
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst) test_mode |-> !cmd_ready); // R6
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst) test_mode |=> cur_state == {$past(cur_state[W-2:0]), $past(scan_si)}); // R4
  AST_FUNC_FOLLOW: assert property (@(posedge clk) disable iff (rst) !test_mode |=> cur_state == $past(nxt_state)); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst) !done |=> (done || $stable(result))); // R7
  AST_SCAN_WINDOW: assert property (@(posedge clk) disable iff (rst) test_mode |-> (tm_run < RW'(W))); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> (cmd_ready && !test_mode)); // R8
endmodule

bind scan_state_ctrl scan_state_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_ready (cmd_ready),
  .test_mode (test_mode),
  .scan_si   (scan_si),
  .nxt_state (nxt_state),
  .cur_state (cur_state),
  .done      (done),
  .result    (result)
);

// File: tb/tb_scan_state_ctrl.sv
`timescale 1ns/1ps
module tb_scan_state_ctrl;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic         cmd_op = 1'b0;
  logic [W-1:0] cmd_data = '0;
  logic [W-1:0] nxt_state;
  logic [W-1:0] cur_state;
  logic         test_mode, scan_si, scan_so, done;
  logic [W-1:0] result;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  function automatic logic [W-1:0] f_next(input logic [W-1:0] s);
    return {s[1] ^ s[0], s[2], ~s[1]};
  endfunction

  assign nxt_state = f_next(cur_state);

  scan_state_ctrl #(.W(W)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .nxt_state(nxt_state),
    .cur_state(cur_state), .test_mode(test_mode), .scan_si(scan_si),
    .scan_so(scan_so), .done(done), .result(result)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 cur_state", 32'(cur_state), 0);
    chk("R1 test_mode", 32'(test_mode), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 result", 32'(result), 0);
    chk("R1 cmd_ready", 32'(cmd_ready), 1);
    rst = 1'b0;
  endtask

  task automatic t_follow();
    logic [W-1:0] prev;
    for (int k = 0; k < 6; k++) begin
      prev = cur_state;
      @(negedge clk);
      chk("R2 follow", 32'(cur_state), 32'(f_next(prev)));
      chk("R2 mode low", 32'(test_mode), 0);
    end
  endtask

  task automatic t_load(input logic [W-1:0] tgt, input logic [W-1:0] res_keep, input bit poke);
    chk("R6 ready before load", 32'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_op = 1'b0; cmd_data = tgt;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < W; k++) begin
      chk("R3 test_mode high", 32'(test_mode), 1);
      chk("R3 scan_si bit", 32'(scan_si), 32'(tgt[W-1-k]));
      chk("R4 scan_so top", 32'(scan_so), 32'(cur_state[W-1]));
      if (poke && k == 1) begin
        chk("R6 busy ready low", 32'(cmd_ready), 0);
        cmd_valid = 1'b1; cmd_op = 1'b1; cmd_data = ~tgt;
      end
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    chk("R3 loaded state", 32'(cur_state), 32'(tgt));
    chk("R3 done", 32'(done), 1);
    chk("R3 mode low", 32'(test_mode), 0);
    chk("R7 result kept on load", 32'(result), 32'(res_keep));
    @(negedge clk);
    chk("R7 done one cycle", 32'(done), 0);
    chk("R8 follows again", 32'(cur_state), 32'(f_next(tgt)));
    if (poke) begin
      for (int k = 0; k < W + 3; k++) begin
        chk("R6 ignored cmd no scan", 32'(test_mode), 0);
        chk("R6 ignored cmd no done", 32'(done), 0);
        @(negedge clk);
      end
      chk("R6 result untouched", 32'(result), 32'(res_keep));
    end
  endtask

  task automatic t_unload(output logic [W-1:0] got);
    logic [W-1:0] exp;
    cmd_valid = 1'b1; cmd_op = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R5 capture mode low", 32'(test_mode), 0);
    exp = f_next(cur_state);
    @(negedge clk);
    for (int k = 0; k < W - 1; k++) begin
      chk("R5 shift mode high", 32'(test_mode), 1);
      chk("R4 scan_so order", 32'(scan_so), 32'(exp[W-1-k]));
      @(negedge clk);
    end
    chk("R5 tail mode low", 32'(test_mode), 0);
    chk("R5 tail last bit", 32'(scan_so), 32'(exp[0]));
    chk("R5 no early done", 32'(done), 0);
    @(negedge clk);
    chk("R5 done", 32'(done), 1);
    chk("R5 result", 32'(result), 32'(exp));
    chk("R6 ready after", 32'(cmd_ready), 1);
    @(negedge clk);
    chk("R7 done drops", 32'(done), 0);
    chk("R7 result holds", 32'(result), 32'(exp));
    got = exp;
  endtask

  initial begin
    logic [W-1:0] last_res;
    @(negedge clk);
    t_reset();
    t_follow();
    last_res = '0;
    for (int v = 0; v < (1 << W); v++) begin
      t_load(W'(v), last_res, 1'b0);
      t_unload(last_res);
    end
    t_load(3'b110, last_res, 1'b1);
    t_follow();
    t_unload(last_res);
    t_reset();
    t_follow();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule